// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block erases a byte range of a page-organised serial flash. A requester gives a start address and a length, both in bytes. The block checks the request, converts it to a page index and a page count, and then issues one erase command per step through a byte-wide SPI transfer port. After each command it polls the device status until the device reports ready, then it moves to the next step.

For each step the block picks one of two erase sizes. If the current page index is a multiple of eight and at least eight pages are left, it erases a block of eight pages. Otherwise it erases one page. This keeps the number of slow device operations low.

Four configuration inputs set the device: its size in bytes, its page size in bytes (which need not be a power of two), the shift that turns a page index into a device page address, and the idle time between status polls. The SPI shifting engine lies outside this block. It accepts one byte per `spi_start` pulse and answers with `spi_done`, which can carry an error flag.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start plus length is greater than `cfg_dev_size` raises `err` for one cycle, issues no SPI byte and returns to idle.
- R2: A request is rejected with a one-cycle `err` and no SPI byte in three cases: the page size is zero, the start is not a whole multiple of the page size, or the length is not a whole multiple of the page size.
- R3: Each step uses opcode 0x50 (eight-page block erase) when the current page index has its three low bits zero and at least eight pages remain. Otherwise it uses opcode 0x81 (single-page erase).
- R4: An erase command is one frame of four bytes: the opcode, bits 23:16 of the device address, bits 15:8 of the device address, then 0x00. The device address is the page index shifted left by `cfg_page_shift`.
- R5: `spi_cs_n` stays low for every byte of a frame and goes high between frames. A status frame is two bytes: 0xD7, then a dummy byte. The byte received during the dummy byte is the status, and status bit 7 set means ready.
- R6: Status frames repeat until a ready status arrives. Before each status frame, `spi_cs_n` is high for exactly `cfg_poll_gap`+1 cycles.
- R7: After a ready status, the page index grows and the remaining page count shrinks by eight after a block erase, or by one after a page erase.
- R8: If any byte of an erase command ends with `spi_err`, the block polls for ready and then repeats that same command without advancing.
- R9: `done` pulses once, for one cycle, after the last page is erased. A valid request of zero length pulses `done` with no erase command.
- R10: While a request is in progress, `req_valid` is ignored.
- R11: Out of reset, `spi_cs_n` is high and `spi_start`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a request (accepted when idle) |
| req_start | input | AW | Start byte address |
| req_len | input | AW | Length in bytes |
| cfg_dev_size | input | AW | Device size in bytes |
| cfg_page_size | input | PW | Page size in bytes |
| cfg_page_shift | input | SW | Left shift from page index to device page address |
| cfg_poll_gap | input | GW | Extra idle cycles before each status poll |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_start | output | 1 | Pulse: transfer `spi_tx_byte` |
| spi_tx_byte | output | 8 | Byte to send |
| spi_done | input | 1 | Pulse: byte transfer finished |
| spi_err | input | 1 | With `spi_done`: the transfer failed |
| spi_rx_byte | input | 8 | Byte received, valid with `spi_done` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Pulse: the request has finished |
| err | output | 1 | Pulse: the request was rejected |

## Verification
The retry path is the hardest case to reach from the ports. It needs a transfer failure in the middle of an erase command, after which a correct design must poll for ready and then send the very same four bytes again. The bench's SPI model can be armed to flag a failure on the second byte of a chosen command. It then looks for a duplicate entry in its log of command frames and checks the extra status frame that comes with it. Polling pace is checked the same way: the model counts how many cycles chip select stays high before each status frame, and it holds the device busy for a set number of polls per command.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS      = 8'hD7;
  localparam int         BLOCK_PAGES    = 8;
  localparam int         DEV_ADDR_W     = 24;
  localparam int         CMD_BYTES      = 4;
  localparam int         STAT_BYTES     = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHK,
    S_DIV_S,
    S_DIV_L,
    S_CMD,
    S_WAIT,
    S_STAT,
    S_NEXT
  } seq_state_t;
endpackage

// File: rtl/flash_erase_div.sv
// Sequential restoring divider: one quotient bit per cycle.
module flash_erase_div #(
  parameter int W  = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic [W-1:0]  quo,
  output logic [DW-1:0] rem,
  output logic          done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  q_q, q_n;
  logic [DW-1:0] r_q, r_n;
  logic [DW-1:0] d_q, d_n;
  logic [CW-1:0] c_q, c_n;
  logic          run_q, run_n;
  logic          done_q, done_n;
  logic [DW:0]   shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {r_q, q_q[W-1]};
    fits    = shifted >= {1'b0, d_q};
    diff    = shifted - {1'b0, d_q};
  end

  always_comb begin
    q_n    = q_q;
    r_n    = r_q;
    d_n    = d_q;
    c_n    = c_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (go) begin
      q_n   = dividend;
      r_n   = '0;
      d_n   = divisor;
      c_n   = '0;
      run_n = 1'b1;
    end else if (run_q) begin
      q_n = {q_q[W-2:0], fits};
      r_n = fits ? diff[DW-1:0] : shifted[DW-1:0];
      c_n = c_q + 1'b1;
      if (c_q == LAST) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      c_q    <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      q_q    <= q_n;
      r_q    <= r_n;
      d_q    <= d_n;
      c_q    <= c_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign quo  = q_q;
  assign rem  = r_q;
  assign done = done_q;

  // R2: the remainder is always below the divisor when reported
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && d_q != '0) |-> (r_q < d_q));
endmodule

// File: rtl/flash_erase_gap.sv
// Down counter that sets the idle time between status polls.
module flash_erase_gap #(
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] value,
  output logic          expired
);
  logic [GW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)             cnt_n = value;
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == '0);

  // R6: without a reload the counter steps down by one each cycle
  a_r6_gap_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/flash_erase_step.sv
// Chooses the erase size for one step and forms the command bytes.
module flash_erase_step
  import flash_erase_pkg::*;
#(
  parameter int IW = 24,
  parameter int SW = 4
) (
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] left,
  input  logic [SW-1:0] shift,
  input  logic [1:0]    bsel,
  output logic          is_block,
  output logic [7:0]    cmd_byte
);
  logic [DEV_ADDR_W-1:0] dev_addr;
  logic [DEV_ADDR_W-1:0] idx_ext;

  always_comb begin
    idx_ext  = DEV_ADDR_W'(idx);
    dev_addr = idx_ext << shift;
    is_block = (idx[2:0] == 3'b000) && (left >= IW'(BLOCK_PAGES));
    unique case (bsel)
      2'd0:    cmd_byte = is_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
      2'd1:    cmd_byte = dev_addr[23:16];
      2'd2:    cmd_byte = dev_addr[15:8];
      default: cmd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int AW = 24,
  parameter int PW = 16,
  parameter int SW = 4,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_len,
  input  logic [AW-1:0] cfg_dev_size,
  input  logic [PW-1:0] cfg_page_size,
  input  logic [SW-1:0] cfg_page_shift,
  input  logic [GW-1:0] cfg_poll_gap,
  output logic          spi_cs_n,
  output logic          spi_start,
  output logic [7:0]    spi_tx_byte,
  input  logic          spi_done,
  input  logic          spi_err,
  input  logic [7:0]    spi_rx_byte,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [1:0] CMD_LAST  = 2'(CMD_BYTES - 1);
  localparam logic [1:0] STAT_LAST = 2'(STAT_BYTES - 1);

  seq_state_t    state_q, state_n;
  logic [AW-1:0] start_q, start_n;
  logic [AW-1:0] len_q, len_n;
  logic [AW-1:0] idx_q, idx_n;
  logic [AW-1:0] left_q, left_n;
  logic          rem_bad_q, rem_bad_n;
  logic [1:0]    bcnt_q, bcnt_n;
  logic          infl_q, infl_n;
  logic          cmd_bad_q, cmd_bad_n;
  logic          done_q, done_n;
  logic          err_q, err_n;

  logic          div_go, div_done;
  logic [AW-1:0] div_quo;
  logic [PW-1:0] div_rem;
  logic          tmr_load, tmr_expired;
  logic          is_block;
  logic [7:0]    cmd_byte;
  logic [AW:0]   end_addr;
  logic [AW-1:0] step_pages;
  logic          in_frame;

  flash_erase_div #(.W(AW), .DW(PW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend ((state_q == S_CHK) ? start_q : len_q),
    .divisor  (cfg_page_size),
    .quo      (div_quo),
    .rem      (div_rem),
    .done     (div_done)
  );

  flash_erase_gap #(.GW(GW)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .value   (cfg_poll_gap),
    .expired (tmr_expired)
  );

  flash_erase_step #(.IW(AW), .SW(SW)) u_step (
    .idx      (idx_q),
    .left     (left_q),
    .shift    (cfg_page_shift),
    .bsel     (bcnt_q),
    .is_block (is_block),
    .cmd_byte (cmd_byte)
  );

  always_comb begin
    end_addr   = {1'b0, start_q} + {1'b0, len_q};
    step_pages = is_block ? AW'(BLOCK_PAGES) : AW'(1);
    in_frame   = (state_q == S_CMD) || (state_q == S_STAT);
  end

  // next-state logic
  always_comb begin
    state_n   = state_q;
    start_n   = start_q;
    len_n     = len_q;
    idx_n     = idx_q;
    left_n    = left_q;
    rem_bad_n = rem_bad_q;
    bcnt_n    = bcnt_q;
    infl_n    = infl_q;
    cmd_bad_n = cmd_bad_q;
    done_n    = 1'b0;
    err_n     = 1'b0;
    div_go    = 1'b0;
    tmr_load  = 1'b0;
    spi_start = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          start_n = req_start;
          len_n   = req_len;
          state_n = S_CHK;
        end
      end
      S_CHK: begin
        if (cfg_page_size == '0 || end_addr > {1'b0, cfg_dev_size}) begin
          err_n   = 1'b1;
          state_n = S_IDLE;
        end else begin
          div_go  = 1'b1;
          state_n = S_DIV_S;
        end
      end
      S_DIV_S: begin
        if (div_done) begin
          idx_n     = div_quo;
          rem_bad_n = (div_rem != '0);
          div_go    = 1'b1;
          state_n   = S_DIV_L;
        end
      end
      S_DIV_L: begin
        if (div_done) begin
          if (rem_bad_q || div_rem != '0) begin
            err_n   = 1'b1;
            state_n = S_IDLE;
          end else if (div_quo == '0) begin
            done_n  = 1'b1;
            state_n = S_IDLE;
          end else begin
            left_n    = div_quo;
            bcnt_n    = '0;
            infl_n    = 1'b0;
            cmd_bad_n = 1'b0;
            state_n   = S_CMD;
          end
        end
      end
      S_CMD: begin
        if (!infl_q) begin
          spi_start = 1'b1;
          infl_n    = 1'b1;
        end else if (spi_done) begin
          infl_n = 1'b0;
          if (spi_err) cmd_bad_n = 1'b1;
          if (bcnt_q == CMD_LAST) begin
            bcnt_n   = '0;
            tmr_load = 1'b1;
            state_n  = S_WAIT;
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (tmr_expired) begin
          bcnt_n  = '0;
          state_n = S_STAT;
        end
      end
      S_STAT: begin
        if (!infl_q) begin
          spi_start = 1'b1;
          infl_n    = 1'b1;
        end else if (spi_done) begin
          infl_n = 1'b0;
          if (bcnt_q == STAT_LAST) begin
            bcnt_n = '0;
            if (!spi_err && spi_rx_byte[7]) begin
              state_n = S_NEXT;
            end else begin
              tmr_load = 1'b1;
              state_n  = S_WAIT;
            end
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end
      end
      S_NEXT: begin
        if (cmd_bad_q) begin
          cmd_bad_n = 1'b0;
          state_n   = S_CMD;
        end else begin
          idx_n  = idx_q + step_pages;
          left_n = left_q - step_pages;
          if (left_q == step_pages) begin
            done_n  = 1'b1;
            state_n = S_IDLE;
          end else begin
            state_n = S_CMD;
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      start_q   <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      left_q    <= '0;
      rem_bad_q <= 1'b0;
      bcnt_q    <= '0;
      infl_q    <= 1'b0;
      cmd_bad_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_n;
      start_q   <= start_n;
      len_q     <= len_n;
      idx_q     <= idx_n;
      left_q    <= left_n;
      rem_bad_q <= rem_bad_n;
      bcnt_q    <= bcnt_n;
      infl_q    <= infl_n;
      cmd_bad_q <= cmd_bad_n;
      done_q    <= done_n;
      err_q     <= err_n;
    end
  end

  always_comb begin
    spi_cs_n = !in_frame;
    if (state_q == S_STAT) spi_tx_byte = (bcnt_q == 2'd0) ? OP_STATUS : 8'h00;
    else                   spi_tx_byte = cmd_byte;
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;
  assign err  = err_q;

  // R5: a byte is only started while chip select is low
  a_r5_start_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_cs_n);

  // R9: done and reject never pulse together
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  // R7: a completed step moves index and count by the same 1 or 8 pages
  a_r7_advance_size: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_NEXT && !$past(cmd_bad_q)) |->
      ((($past(left_q) - left_q) == AW'(1)) || (($past(left_q) - left_q) == AW'(BLOCK_PAGES)))
      && ((idx_q - $past(idx_q)) == ($past(left_q) - left_q)));

  // R8: a failed command leaves the position unchanged for the retry
  a_r8_retry_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == S_NEXT && $past(cmd_bad_q)) |->
      (idx_q == $past(idx_q)) && (left_q == $past(left_q)));

  // R10: the latched request does not change while work is in progress
  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != S_IDLE) |-> ($stable(start_q) && $stable(len_q)));
endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
  localparam int AW = 24, PW = 16, SW = 4, GW = 16;
  localparam int GAP = 3;
  localparam int NV  = 9;
  // {page[15:0], shift[3:0], start[23:0], len[23:0], expect_err, busy_polls[3:0]}
  localparam logic [72:0] VEC [NV] = '{
    {16'd256, 4'd8,  24'd0,     24'd4096,  1'b0, 4'd2},
    {16'd264, 4'd9,  24'd792,   24'd2640,  1'b0, 4'd0},
    {16'd264, 4'd9,  24'd2112,  24'd2376,  1'b0, 4'd1},
    {16'd256, 4'd8,  24'd100,   24'd256,   1'b1, 4'd0},
    {16'd256, 4'd8,  24'd0,     24'd300,   1'b1, 4'd0},
    {16'd256, 4'd8,  24'd15360, 24'd1280,  1'b1, 4'd0},
    {16'd256, 4'd8,  24'd14336, 24'd2048,  1'b0, 4'd3},
    {16'd528, 4'd10, 24'd3696,  24'd4752,  1'b0, 4'd1},
    {16'd256, 4'd8,  24'd0,     24'd0,     1'b0, 4'd0}
  };

  logic          clk, rst_n;
  logic          req_valid;
  logic [AW-1:0] req_start, req_len, cfg_dev_size;
  logic [PW-1:0] cfg_page_size;
  logic [SW-1:0] cfg_page_shift;
  logic [GW-1:0] cfg_poll_gap;
  logic          spi_cs_n, spi_start, spi_done, spi_err, busy, done, err;
  logic [7:0]    spi_tx_byte, spi_rx_byte;

  flash_erase_seq #(.AW(AW), .PW(PW), .SW(SW), .GW(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
    .req_len(req_len), .cfg_dev_size(cfg_dev_size), .cfg_page_size(cfg_page_size),
    .cfg_page_shift(cfg_page_shift), .cfg_poll_gap(cfg_poll_gap),
    .spi_cs_n(spi_cs_n), .spi_start(spi_start), .spi_tx_byte(spi_tx_byte),
    .spi_done(spi_done), .spi_err(spi_err), .spi_rx_byte(spi_rx_byte),
    .busy(busy), .done(done), .err(err));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests, fails;
  // SPI device model state
  logic [7:0] fr [4];
  int flen, ncmd, nstat, busy_cfg, busy_left, n_done, n_err, nbytes;
  int run_len, last_run, gap_bad, inj_idx;
  logic [31:0] log_cmd [64];
  logic prev_cs, pend;
  logic [7:0] cur_byte;
  int lat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_done <= 1'b0; spi_err <= 1'b0; spi_rx_byte <= 8'h00;
      pend = 1'b0; lat = 0; prev_cs = 1'b1;
    end else begin
      spi_done <= 1'b0; spi_err <= 1'b0;
      if (done) n_done++;
      if (err)  n_err++;
      if (prev_cs && !spi_cs_n) begin last_run = run_len; run_len = 0; flen = 0; end
      if (spi_cs_n) run_len++;
      if (!prev_cs && spi_cs_n) begin
        if (flen == 4) begin
          if (ncmd < 64) log_cmd[ncmd] = {fr[0], fr[1], fr[2], fr[3]};
          ncmd++; busy_left = busy_cfg;
        end else if (flen == 2) nstat++;
      end
      prev_cs = spi_cs_n;
      if (spi_start) begin
        nbytes++;
        if (flen == 0 && spi_tx_byte == 8'hD7 && last_run != GAP + 1) gap_bad++;
        if (flen < 4) fr[flen] = spi_tx_byte;
        cur_byte = spi_tx_byte;
        flen++; pend = 1'b1; lat = 2;
      end else if (pend) begin
        if (lat == 0) begin
          pend = 1'b0;
          spi_done <= 1'b1;
          spi_rx_byte <= 8'h00;
          if (flen == 2 && fr[0] == 8'hD7) begin
            spi_rx_byte <= (busy_left == 0) ? 8'h9C : 8'h1C;
            if (busy_left > 0) busy_left--;
          end
          if (fr[0] != 8'hD7 && flen == 2 && ncmd == inj_idx) begin
            spi_err <= 1'b1; inj_idx = -1;
          end
        end else lat--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    ncmd = 0; nstat = 0; n_done = 0; n_err = 0; gap_bad = 0; nbytes = 0;
  endtask

  task automatic apply_cfg(input int pg, input int sh, input int bz);
    cfg_page_size = PW'(pg); cfg_page_shift = SW'(sh);
    cfg_dev_size = AW'(pg * 64); busy_cfg = bz;
  endtask

  task automatic pulse_req(input int st, input int ln);
    @(negedge clk);
    req_start = AW'(st); req_len = AW'(ln); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (n_done + n_err > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // reference command list from R3/R4/R7; dup >= 0 repeats that entry (R8)
  task automatic check_cmds(input int pg, input int sh, input int st, input int ln,
                            input int dup, input string req);
    int idx, left, k, bad, expn;
    logic [7:0] op; logic [23:0] a;
    idx = st / pg; left = ln / pg; k = 0; bad = 0; expn = 0;
    while (left > 0) begin
      bit blk;
      blk = (idx % 8 == 0) && (left >= 8);
      op = blk ? 8'h50 : 8'h81;
      a = 24'(idx << sh);
      for (int r = 0; r < ((expn == dup) ? 2 : 1); r++) begin
        if (k < 64 && log_cmd[k] != {op, a[23:16], a[15:8], 8'h00}) bad++;
        k++;
      end
      expn++;
      if (blk) begin idx += 8; left -= 8; end else begin idx += 1; left -= 1; end
    end
    check(ncmd == k, req, "command count", ncmd, k);
    check(bad == 0, req, "command bytes mismatching", bad, 0);
  endtask

  int wd;
  initial begin
    wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected below %0d", wd, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    tests = 0; fails = 0; inj_idx = -1; run_len = 0; last_run = 0; flen = 0;
    busy_left = 0; clear_model();
    req_valid = 1'b0; req_start = '0; req_len = '0; cfg_poll_gap = GW'(GAP);
    apply_cfg(256, 8, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(spi_cs_n && !spi_start && !busy && !done && !err, "R11", "reset outputs",
          {spi_cs_n, spi_start, busy, done, err}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(spi_cs_n && !busy, "R11", "idle after release", {spi_cs_n, busy}, 2'b10);

    // vector table: R1 R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      int pg, sh, st, ln, bz; bit xe;
      pg = int'(VEC[v][72:57]); sh = int'(VEC[v][56:53]);
      st = int'(VEC[v][52:29]); ln = int'(VEC[v][28:5]);
      xe = VEC[v][4]; bz = int'(VEC[v][3:0]);
      clear_model(); apply_cfg(pg, sh, bz);
      pulse_req(st, ln);
      wait_end();
      if (xe) begin
        check(n_err == 1 && n_done == 0, "R1/R2", "reject pulses", n_err, 1);
        check(nbytes == 0, "R2", "bytes sent on reject", nbytes, 0);
      end else begin
        check(n_done == 1 && n_err == 0, "R9", "done pulses", n_done, 1);
        check_cmds(pg, sh, st, ln, -1, "R3/R4/R7");
        check(nstat == ncmd * (bz + 1), "R6", "status frames", nstat, ncmd * (bz + 1));
        check(gap_bad == 0, "R6", "poll gap mismatches", gap_bad, 0);
      end
    end

    // R2: zero page size rejected
    clear_model(); apply_cfg(0, 8, 0);
    pulse_req(0, 0); wait_end();
    check(n_err == 1 && nbytes == 0, "R2", "zero page size", n_err, 1);

    // R1: end exactly one page past the device
    clear_model(); apply_cfg(256, 8, 0);
    pulse_req(64 * 256, 256); wait_end();
    check(n_err == 1 && nbytes == 0, "R1", "range just past end", n_err, 1);

    // R8: failure on second command is retried with identical bytes
    clear_model(); apply_cfg(264, 9, 1); inj_idx = 1;
    pulse_req(2 * 264, 3 * 264); wait_end();
    check(n_done == 1, "R8", "done after retry", n_done, 1);
    check_cmds(264, 9, 2 * 264, 3 * 264, 1, "R8");
    check(nstat == 4 * 2, "R8", "status frames with retry", nstat, 8);

    // R10: request during activity ignored
    clear_model(); apply_cfg(256, 8, 1);
    pulse_req(0, 16 * 256);
    repeat (60) @(negedge clk);
    pulse_req(100, 256);
    wait_end();
    repeat (20) @(negedge clk);
    check(n_err == 0 && n_done == 1, "R10", "second request ignored", n_err, 0);
    check_cmds(256, 8, 0, 16 * 256, -1, "R10");

    // R5: block idle with chip select high after finishing
    check(spi_cs_n && !busy, "R5", "cs released at end", spi_cs_n, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule